// File: doc/BRIEF.md
# Burst Address Sequence Generator

The block turns one burst request into a stream of per-beat addresses on a point-to-point master/slave core interface. A single request carries a base address, an ordering code and, for a burst of known length, a beat count. From then on the block presents one address per beat on a valid/ready handshake. It steps to the next address each time a beat is accepted.

Four orderings are available: incrementing, wrapping inside an aligned block, constant (streaming) and XOR inside an aligned block. A burst of known length ends on its own after the programmed number of beats. An open-ended burst runs until the requester marks an accepted beat as the last one. Each beat address is held in registers and is already on the output before the cycle in which that beat is consumed, so a target can fetch ahead. A request that cannot be honoured raises a one-cycle error flag and produces no beats.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `beat_valid_o`, `busy_o`, `last_o` and `err_o` are all low.
- R2: A request with `start_i` high while `busy_o` is low is accepted at that rising edge. From the next cycle, `beat_valid_o` and `busy_o` are high and `addr_o` equals the captured base address.
- R3: With `seq_i` = 3'b000 (incrementing), beat k has address base + k*WORD_BYTES.
- R4: With `seq_i` = 3'b001 (wrapping), beat k has address (base & ~M) | ((base + k*WORD_BYTES) & M), where M = count*WORD_BYTES - 1.
- R5: With `seq_i` = 3'b010 (streaming), every beat has the base address.
- R6: With `seq_i` = 3'b011 (XOR), beat k has address base XOR (k*WORD_BYTES).
- R7: In a burst of known length (`precise_i` = 1), `last_o` is high exactly on beat count-1. `busy_o` and `beat_valid_o` drop in the cycle after that beat is accepted.
- R8: In an open-ended burst (`precise_i` = 0), `last_o` follows `beat_last_i` while a beat is valid. The burst ends only when a beat is accepted with `beat_last_i` high.
- R9: Any of the following requests raises `err_o` for exactly the one cycle after the request edge and generates no beat: a `seq_i` code from 3'b100 to 3'b111; wrapping or XOR with a count that is not a power of two, or with `precise_i` = 0; or a precise count of zero.
- R10: `start_i` while `busy_o` is high is ignored. The running burst keeps its addresses and length.
- R11: While `beat_valid_o` is high and `beat_ready_i` is low, `addr_o` and `beat_valid_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request strobe |
| base_addr_i | input | AW | Address of the first beat |
| seq_i | input | 3 | Ordering code |
| precise_i | input | 1 | 1: length given by count_i; 0: open-ended |
| count_i | input | CW | Beat count for known-length bursts |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_last_i | input | 1 | Requester marks the current beat as last (open-ended) |
| beat_valid_o | output | 1 | A beat address is presented |
| addr_o | output | AW | Address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress; new requests are ignored |
| err_o | output | 1 | Rejected request, one-cycle pulse |

## Verification
A wrong beat index or captured base shows up as a bad `addr_o` on the very beat it belongs to. Each burst is therefore checked address by address against values worked out from the ordering formulas. A miscounted length shows up as `last_o` on the wrong beat, or as `busy_o` staying high or dropping one cycle away from the accepted last beat. Bad request decoding shows up in the cycle after the request as a missing error pulse or as a stray valid beat. Stalls and requests made while busy are applied in the middle of a burst, so that a corrupted hold or capture appears on the next beat address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_INCR   = 3'd0,
    SEQ_WRAP   = 3'd1,
    SEQ_STREAM = 3'd2,
    SEQ_XOR    = 3'd3
  } seq_e;
endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
  import burst_seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [2:0]    seq_i,
  input  logic          precise_i,
  input  logic [CW-1:0] count_i,
  output logic          bad_o
);
  logic pow2;
  logic blocked;

  assign pow2 = (count_i != '0) && ((count_i & (count_i - 1'b1)) == '0);

  always_comb begin
    unique case (seq_i)
      SEQ_INCR, SEQ_STREAM: blocked = precise_i && (count_i == '0);
      SEQ_WRAP, SEQ_XOR:    blocked = !precise_i || !pow2;
      default:              blocked = 1'b1;
    endcase
  end

  assign bad_o = blocked;
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bad_i,
  input  logic          precise_i,
  input  logic [CW-1:0] count_i,
  input  logic          ready_i,
  input  logic          last_i,
  output logic          load_o,
  output logic          busy_o,
  output logic [CW-1:0] idx_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          err_o
);
  logic          busy_q, precise_q, err_q;
  logic [CW-1:0] idx_q, cnt_q;
  logic          accept;

  assign accept = start_i & ~busy_q;
  assign load_o = accept & ~bad_i;
  assign last_o = busy_q & (precise_q ? (idx_q == cnt_q - 1'b1) : last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      precise_q <= 1'b0;
      err_q     <= 1'b0;
      idx_q     <= '0;
      cnt_q     <= '0;
    end else begin
      err_q <= accept & bad_i;
      if (load_o) begin
        busy_q    <= 1'b1;
        idx_q     <= '0;
        cnt_q     <= count_i;
        precise_q <= precise_i;
      end else if (busy_q && ready_i) begin
        if (last_o) busy_q <= 1'b0;
        else        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign cnt_o  = cnt_q;
  assign err_o  = err_q;
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_seq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 8,
  parameter int LOG_WB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [2:0]    seq_i,
  input  logic [CW-1:0] idx_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  seq_e          seq_q;
  logic [AW-1:0] offset, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      seq_q  <= SEQ_INCR;
    end else if (load_i) begin
      base_q <= base_i;
      seq_q  <= seq_e'(seq_i);
    end
  end

  assign offset = AW'(idx_i) << LOG_WB;
  assign mask   = (AW'(cnt_i) << LOG_WB) - 1'b1;

  always_comb begin
    unique case (seq_q)
      SEQ_INCR:   addr_o = base_q + offset;
      SEQ_WRAP:   addr_o = (base_q & ~mask) | ((base_q + offset) & mask);
      SEQ_XOR:    addr_o = base_q ^ offset;
      default:    addr_o = base_q;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW         = 32,
  parameter int CW         = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [2:0]    seq_i,
  input  logic          precise_i,
  input  logic [CW-1:0] count_i,
  input  logic          beat_ready_i,
  input  logic          beat_last_i,
  output logic          beat_valid_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          busy_o,
  output logic          err_o
);
  localparam int LOG_WB = $clog2(WORD_BYTES);

  logic          bad, load;
  logic [CW-1:0] idx, cnt;

  burst_req_check #(.CW(CW)) u_check (
    .seq_i     (seq_i),
    .precise_i (precise_i),
    .count_i   (count_i),
    .bad_o     (bad)
  );

  burst_beat_ctrl #(.CW(CW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .bad_i     (bad),
    .precise_i (precise_i),
    .count_i   (count_i),
    .ready_i   (beat_ready_i),
    .last_i    (beat_last_i),
    .load_o    (load),
    .busy_o    (busy_o),
    .idx_o     (idx),
    .cnt_o     (cnt),
    .last_o    (last_o),
    .err_o     (err_o)
  );

  burst_addr_calc #(.AW(AW), .CW(CW), .LOG_WB(LOG_WB)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (base_addr_i),
    .seq_i  (seq_i),
    .idx_i  (idx),
    .cnt_i  (cnt),
    .addr_o (addr_o)
  );

  assign beat_valid_o = busy_o;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] base_addr_i,
  input logic          beat_ready_i,
  input logic          beat_valid_o,
  input logic [AW-1:0] addr_o,
  input logic          last_o,
  input logic          busy_o,
  input logic          err_o
);
  assert_first_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> ((beat_valid_o && addr_o == $past(base_addr_i)) || err_o));

  assert_end_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && last_o) |=> !busy_o);

  assert_err_no_beat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !beat_valid_o);

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_busy_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(beat_ready_i && last_o)) |=> busy_o);

  assert_stall_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(addr_o)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .base_addr_i  (base_addr_i),
  .beat_ready_i (beat_ready_i),
  .beat_valid_o (beat_valid_o),
  .addr_o       (addr_o),
  .last_o       (last_o),
  .busy_o       (busy_o),
  .err_o        (err_o)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [2:0]  seq_i = '0;
  logic        precise_i = 1'b0;
  logic [7:0]  count_i = '0;
  logic        beat_ready_i = 1'b0;
  logic        beat_last_i = 1'b0;
  logic        beat_valid_o, last_o, busy_o, err_o;
  logic [31:0] addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_addr_gen dut (.*);

  typedef struct packed {
    logic [2:0]  seq;
    logic [7:0]  cnt;
    logic [31:0] base;
    logic [31:0] e0, e1, e2, e3;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd3, 32'h100, 32'h100, 32'h104, 32'h108, 32'h0},  // R3
    '{3'd1, 8'd4, 32'h01C, 32'h01C, 32'h010, 32'h014, 32'h018}, // R4
    '{3'd2, 8'd3, 32'h040, 32'h040, 32'h040, 32'h040, 32'h0},  // R5
    '{3'd3, 8'd4, 32'h01C, 32'h01C, 32'h018, 32'h014, 32'h010}, // R6
    '{3'd3, 8'd4, 32'h024, 32'h024, 32'h020, 32'h02C, 32'h028}, // R6
    '{3'd1, 8'd2, 32'h00C, 32'h00C, 32'h008, 32'h0,   32'h0},  // R4
    '{3'd0, 8'd1, 32'h050, 32'h050, 32'h0,   32'h0,   32'h0}   // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic request(input logic [2:0] s, input logic p, input logic [7:0] c,
                         input logic [31:0] b);
    step();
    start_i = 1'b1; seq_i = s; precise_i = p; count_i = c; base_addr_i = b;
    step();
    start_i = 1'b0;
    #2;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step();
    #2;
    chk("R1 valid", 32'(beat_valid_o), 32'd0);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 err", 32'(err_o), 32'd0);
    chk("R1 last", 32'(last_o), 32'd0);
    rst_ni = 1'b1;

    // table walk: known-length bursts, consumer always ready
    for (int v = 0; v < NV; v++) begin
      logic [31:0] exp [4];
      exp[0] = VECS[v].e0; exp[1] = VECS[v].e1; exp[2] = VECS[v].e2; exp[3] = VECS[v].e3;
      beat_ready_i = 1'b1;
      request(VECS[v].seq, 1'b1, VECS[v].cnt, VECS[v].base);
      chk("R2 valid first beat", 32'(beat_valid_o), 32'd1);
      for (int k = 0; k < int'(VECS[v].cnt); k++) begin
        chk("R3-6 table addr", addr_o, exp[k]);
        chk("R7 last flag", 32'(last_o), 32'(k == int'(VECS[v].cnt) - 1));
        step();
        #2;
      end
      chk("R7 busy after last", 32'(busy_o), 32'd0);
      chk("R7 valid after last", 32'(beat_valid_o), 32'd0);
    end

    // R8: open-ended incrementing burst, last marked on fifth beat
    beat_ready_i = 1'b1;
    request(3'd0, 1'b0, 8'd0, 32'h200);
    for (int k = 0; k < 5; k++) begin
      beat_last_i = (k == 4);
      #1;
      chk("R8 addr", addr_o, 32'h200 + 32'(k * 4));
      chk("R8 last mirrors", 32'(last_o), 32'(k == 4));
      chk("R8 busy", 32'(busy_o), 32'd1);
      step();
      beat_last_i = 1'b0;
      #2;
    end
    chk("R8 ended", 32'(busy_o), 32'd0);

    // R11: stall in a wrapping burst
    request(3'd1, 1'b1, 8'd4, 32'h01C);
    step(); #2;
    chk("R11 second beat", addr_o, 32'h010);
    beat_ready_i = 1'b0;
    step(); #2;
    chk("R11 held addr", addr_o, 32'h010);
    chk("R11 held valid", 32'(beat_valid_o), 32'd1);
    step(); #2;
    chk("R11 still held", addr_o, 32'h010);
    beat_ready_i = 1'b1;
    step(); #2;
    chk("R11 resumes", addr_o, 32'h014);
    step(); #2;
    step(); #2;
    chk("R11 burst over", 32'(busy_o), 32'd0);

    // R10: request while busy is ignored
    request(3'd0, 1'b1, 8'd3, 32'h300);
    start_i = 1'b1; seq_i = 3'd2; count_i = 8'd8; base_addr_i = 32'h999;
    step(); #2;
    start_i = 1'b0;
    chk("R10 addr unchanged", addr_o, 32'h304);
    step(); #2;
    chk("R10 addr third", addr_o, 32'h308);
    chk("R10 length kept", 32'(last_o), 32'd1);
    step(); #2;
    chk("R10 ended", 32'(busy_o), 32'd0);

    // R9: rejected requests
    request(3'd5, 1'b1, 8'd4, 32'h400);
    chk("R9 reserved code err", 32'(err_o), 32'd1);
    chk("R9 reserved code no beat", 32'(beat_valid_o), 32'd0);
    step(); #2;
    chk("R9 pulse one cycle", 32'(err_o), 32'd0);
    chk("R9 still idle", 32'(busy_o), 32'd0);
    request(3'd1, 1'b1, 8'd3, 32'h400);
    chk("R9 wrap non-pow2 err", 32'(err_o), 32'd1);
    chk("R9 wrap non-pow2 no beat", 32'(beat_valid_o), 32'd0);
    request(3'd3, 1'b0, 8'd4, 32'h400);
    chk("R9 xor open-ended err", 32'(err_o), 32'd1);
    request(3'd0, 1'b1, 8'd0, 32'h400);
    chk("R9 zero count err", 32'(err_o), 32'd1);
    chk("R9 zero count no beat", 32'(beat_valid_o), 32'd0);
    step(); #2;
    chk("R9 cleared", 32'(err_o), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule